// File: doc/BRIEF.md
# Zero-Overhead Loop Sequencer

This block sits next to the fetch stage of a 32-bit in-order core and repeats loop bodies without any compare or branch instruction inside the loop. It holds two loop contexts. Each context keeps a first-instruction address, a last-instruction address and a remaining-iteration count. Context 0 serves as the inner loop and context 1 as the outer loop. Once a context is loaded, the fetch stage only has to follow the redirect this block raises.

Contexts are loaded by commands from decode. Three per-field commands write the first address, the last address or the count of one context. These commands accept any address. One combined command loads a whole context at once: the first address is the command's own PC plus 4, the last address is that value plus a byte offset, and the count comes with the same command. Decode supplies the count already chosen from a register or an immediate. On each valid fetch, the block compares the fetch PC against the last address of every live context. A context is live while its count is nonzero. It then either raises a jump back to the first address or lets the last pass fall through.

Top module: `zol_seq`

## Requirements
- R1: After reset, every count, first address and last address reads zero, and no redirect is raised.
- R2: A command with op code 1 writes `cmd_addr` into the first address of the context named by `cmd_set`, and it is visible on the next cycle.
- R3: A command with op code 2 writes `cmd_addr` into the last address of the selected context, and it is visible on the next cycle.
- R4: A command with op code 3 writes `cmd_cnt` into the count of the selected context, and it is visible on the next cycle.
- R5: A command with op code 4 loads, in one cycle, first = `cmd_pc` + 4, last = `cmd_pc` + 4 + `cmd_off` and count = `cmd_cnt` into the selected context. Op code 0 does nothing.
- R6: When `fetch_valid` is high, `fetch_pc` equals the last address of the winning live context and that context's count is above 1, `redirect_valid` is high in the same cycle with `redirect_pc` equal to that context's first address. The count then drops by one on the next cycle. A fetch PC that matches no last address raises no redirect.
- R7: When the winning context's count is exactly 1 at its last address, no redirect is raised and the count becomes 0.
- R8: A context whose count is 0 never redirects and never changes its count on a fetch.
- R9: When both live contexts match the fetch PC, context 0 wins, and context 1 keeps its count.
- R10: A command writing the count of a context in the same cycle as that context's decrement sets the count to the commanded value. The redirect of that cycle still uses the old values.
- R11: With `fetch_valid` low, no redirect is raised and no count changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Setup command present |
| cmd_op | input | 3 | 0 none, 1 first address, 2 last address, 3 count, 4 combined |
| cmd_set | input | 1 | Context index addressed by the command |
| cmd_pc | input | 32 | PC of the setup command (combined form) |
| cmd_addr | input | 32 | Address for op codes 1 and 2 |
| cmd_off | input | 32 | Byte offset from first to last address (combined form) |
| cmd_cnt | input | 16 | Iteration count, already chosen from register or immediate |
| fetch_valid | input | 1 | Fetch PC is valid |
| fetch_pc | input | 32 | Current fetch PC |
| redirect_valid | output | 1 | Jump back to a loop's first address |
| redirect_pc | output | 32 | Target of the jump |
| loop_start_o | output | 64 | First addresses, context 0 in the low 32 bits |
| loop_end_o | output | 64 | Last addresses, context 0 in the low 32 bits |
| loop_cnt_o | output | 32 | Counts, context 0 in the low 16 bits |

## Verification
The redirect is combinational from the fetch PC and the stored contexts, so it is due in the same cycle as the fetch. Every register change, whether from a command or a decrement, shows up one cycle after the edge that captures it. Stimulus is applied on the falling edge. The redirect is sampled a nanosecond later, before the next rising edge, and the context outputs are sampled a nanosecond after that rising edge. This way, each queued expectation is compared in exactly the cycle in which it falls due.

// File: rtl/zol_pkg.sv
package zol_pkg;
  typedef enum logic [2:0] {
    ZOL_NONE  = 3'd0,
    ZOL_FIRST = 3'd1,
    ZOL_LAST  = 3'd2,
    ZOL_COUNT = 3'd3,
    ZOL_ALL   = 3'd4
  } zol_op_e;

  localparam int unsigned INSN_BYTES = 4;
endpackage

// File: rtl/zol_ctx.sv
module zol_ctx #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_first,
  input  logic              wr_last,
  input  logic              wr_cnt,
  input  logic              dec_en,
  input  logic [ADDR_W-1:0] first_d,
  input  logic [ADDR_W-1:0] last_d,
  input  logic [CNT_W-1:0]  cnt_d,
  output logic [ADDR_W-1:0] first_q,
  output logic [ADDR_W-1:0] last_q,
  output logic [CNT_W-1:0]  cnt_q
);
  logic [CNT_W-1:0] cnt_n;
  logic             cnt_en;

  always_comb begin
    cnt_en = wr_cnt | dec_en;
    if (wr_cnt) cnt_n = cnt_d;
    else        cnt_n = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      first_q <= '0;
      last_q  <= '0;
      cnt_q   <= '0;
    end else begin
      if (wr_first) first_q <= first_d;
      if (wr_last)  last_q  <= last_d;
      if (cnt_en)   cnt_q   <= cnt_n;
    end
  end
endmodule

// File: rtl/zol_pick.sv
module zol_pick #(
  parameter int unsigned NSETS  = 2,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic                          fetch_valid,
  input  logic [ADDR_W-1:0]             fetch_pc,
  input  logic [NSETS-1:0][ADDR_W-1:0]  first_a,
  input  logic [NSETS-1:0][ADDR_W-1:0]  last_a,
  input  logic [NSETS-1:0][CNT_W-1:0]   cnt_a,
  output logic [NSETS-1:0]              dec_o,
  output logic                          jump_o,
  output logic [ADDR_W-1:0]             target_o
);
  logic [NSETS-1:0] hit;

  always_comb begin
    for (int i = 0; i < NSETS; i++)
      hit[i] = fetch_valid && (fetch_pc == last_a[i]) && (cnt_a[i] != '0);
  end

  // lowest index wins: context 0 is the innermost loop
  always_comb begin
    logic taken;
    taken    = 1'b0;
    dec_o    = '0;
    jump_o   = 1'b0;
    target_o = '0;
    for (int i = 0; i < NSETS; i++) begin
      if (hit[i] && !taken) begin
        taken    = 1'b1;
        dec_o[i] = 1'b1;
        jump_o   = (cnt_a[i] > CNT_W'(1));
        target_o = first_a[i];
      end
    end
  end
endmodule

// File: rtl/zol_seq.sv
module zol_seq #(
  parameter  int unsigned NSETS  = 2,
  parameter  int unsigned ADDR_W = 32,
  parameter  int unsigned CNT_W  = 16,
  localparam int unsigned SET_IW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cmd_valid,
  input  logic [2:0]              cmd_op,
  input  logic [SET_IW-1:0]       cmd_set,
  input  logic [ADDR_W-1:0]       cmd_pc,
  input  logic [ADDR_W-1:0]       cmd_addr,
  input  logic [ADDR_W-1:0]       cmd_off,
  input  logic [CNT_W-1:0]        cmd_cnt,
  input  logic                    fetch_valid,
  input  logic [ADDR_W-1:0]       fetch_pc,
  output logic                    redirect_valid,
  output logic [ADDR_W-1:0]       redirect_pc,
  output logic [NSETS*ADDR_W-1:0] loop_start_o,
  output logic [NSETS*ADDR_W-1:0] loop_end_o,
  output logic [NSETS*CNT_W-1:0]  loop_cnt_o
);
  import zol_pkg::*;

  logic [1:0] rst_pipe;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_q_n = rst_pipe[1];

  logic [NSETS-1:0][ADDR_W-1:0] first_a, last_a;
  logic [NSETS-1:0][CNT_W-1:0]  cnt_a;
  logic [NSETS-1:0]             dec;
  logic [ADDR_W-1:0]            fast_first, fast_last;
  logic                         op_first, op_last, op_cnt, op_all;

  always_comb begin
    op_all     = cmd_valid && (cmd_op == ZOL_ALL);
    op_first   = cmd_valid && (cmd_op == ZOL_FIRST);
    op_last    = cmd_valid && (cmd_op == ZOL_LAST);
    op_cnt     = cmd_valid && (cmd_op == ZOL_COUNT);
    fast_first = cmd_pc + ADDR_W'(INSN_BYTES);
    fast_last  = fast_first + cmd_off;
  end

  for (genvar g = 0; g < NSETS; g++) begin : g_ctx
    logic sel;
    logic [ADDR_W-1:0] first_d, last_d;
    assign sel     = (cmd_set == SET_IW'(g));
    assign first_d = op_all ? fast_first : cmd_addr;
    assign last_d  = op_all ? fast_last  : cmd_addr;

    zol_ctx #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_ctx (
      .clk      (clk),
      .rst_n    (rst_q_n),
      .wr_first (sel && (op_first || op_all)),
      .wr_last  (sel && (op_last  || op_all)),
      .wr_cnt   (sel && (op_cnt   || op_all)),
      .dec_en   (dec[g]),
      .first_d  (first_d),
      .last_d   (last_d),
      .cnt_d    (cmd_cnt),
      .first_q  (first_a[g]),
      .last_q   (last_a[g]),
      .cnt_q    (cnt_a[g])
    );
  end

  zol_pick #(.NSETS(NSETS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_pick (
    .fetch_valid (fetch_valid),
    .fetch_pc    (fetch_pc),
    .first_a     (first_a),
    .last_a      (last_a),
    .cnt_a       (cnt_a),
    .dec_o       (dec),
    .jump_o      (redirect_valid),
    .target_o    (redirect_pc)
  );

  assign loop_start_o = first_a;
  assign loop_end_o   = last_a;
  assign loop_cnt_o   = cnt_a;
endmodule

// File: rtl/zol_seq_chk.sv
module zol_seq_chk #(
  parameter  int unsigned NSETS  = 2,
  parameter  int unsigned ADDR_W = 32,
  parameter  int unsigned CNT_W  = 16,
  localparam int unsigned SET_IW = (NSETS > 1) ? $clog2(NSETS) : 1
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    cmd_valid,
  input logic [2:0]              cmd_op,
  input logic [SET_IW-1:0]       cmd_set,
  input logic [ADDR_W-1:0]       cmd_pc,
  input logic [ADDR_W-1:0]       cmd_off,
  input logic [CNT_W-1:0]        cmd_cnt,
  input logic                    fetch_valid,
  input logic [ADDR_W-1:0]       fetch_pc,
  input logic                    redirect_valid,
  input logic [ADDR_W-1:0]       redirect_pc,
  input logic [NSETS*ADDR_W-1:0] loop_start_o,
  input logic [NSETS*ADDR_W-1:0] loop_end_o,
  input logic [NSETS*CNT_W-1:0]  loop_cnt_o
);
  import zol_pkg::*;

  logic [ADDR_W-1:0] s0, e0, e1;
  logic [CNT_W-1:0]  c0, c1;
  logic              cw0, cw1, tgt_ok;

  always_comb begin
    s0  = loop_start_o[ADDR_W-1:0];
    e0  = loop_end_o[ADDR_W-1:0];
    e1  = loop_end_o[2*ADDR_W-1:ADDR_W];
    c0  = loop_cnt_o[CNT_W-1:0];
    c1  = loop_cnt_o[2*CNT_W-1:CNT_W];
    cw0 = cmd_valid && (cmd_set == SET_IW'(0)) && (cmd_op == ZOL_COUNT || cmd_op == ZOL_ALL);
    cw1 = cmd_valid && (cmd_set == SET_IW'(1)) && (cmd_op == ZOL_COUNT || cmd_op == ZOL_ALL);
    tgt_ok = 1'b0;
    for (int i = 0; i < NSETS; i++)
      if (redirect_pc == loop_start_o[i*ADDR_W +: ADDR_W]) tgt_ok = 1'b1;
  end

  a_r11_no_jump_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |-> !redirect_valid);

  a_r11_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!fetch_valid && !cmd_valid) |=> $stable(loop_cnt_o));

  a_r6_target_is_first: assert property (@(posedge clk) disable iff (!rst_n)
    redirect_valid |-> tgt_ok);

  a_r6_jump_ctx0: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_pc == e0 && c0 > CNT_W'(1)) |-> (redirect_valid && redirect_pc == s0));

  a_r6_dec_ctx0: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_pc == e0 && c0 != '0 && !cw0) |=> (c0 == $past(c0) - CNT_W'(1)));

  a_r7_last_pass: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_pc == e0 && c0 == CNT_W'(1)) |-> !redirect_valid);

  a_r9_outer_waits: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && fetch_pc == e0 && c0 != '0 && fetch_pc == e1 && c1 != '0 && !cw1)
      |=> (c1 == $past(c1)));

  a_r10_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cw0 |=> (c0 == $past(cmd_cnt)));

  a_r5_combined: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == ZOL_ALL && cmd_set == SET_IW'(0))
      |=> (s0 == $past(cmd_pc) + ADDR_W'(INSN_BYTES) &&
           e0 == $past(cmd_pc) + ADDR_W'(INSN_BYTES) + $past(cmd_off)));
endmodule

bind zol_seq zol_seq_chk #(.NSETS(NSETS), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_q_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_set(cmd_set),
  .cmd_pc(cmd_pc), .cmd_off(cmd_off), .cmd_cnt(cmd_cnt), .fetch_valid(fetch_valid),
  .fetch_pc(fetch_pc), .redirect_valid(redirect_valid), .redirect_pc(redirect_pc),
  .loop_start_o(loop_start_o), .loop_end_o(loop_end_o), .loop_cnt_o(loop_cnt_o)
);

// File: tb/sim_zol_seq.sv
module sim_zol_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [0:0]  cmd_set = '0;
  logic [31:0] cmd_pc = '0, cmd_addr = '0, cmd_off = '0;
  logic [15:0] cmd_cnt = '0;
  logic        fetch_valid = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        redirect_valid;
  logic [31:0] redirect_pc;
  logic [63:0] loop_start_o, loop_end_o;
  logic [31:0] loop_cnt_o;

  always #2 clk = ~clk;

  zol_seq u0 (.*);

  typedef struct {
    string       req;
    bit          rv;
    logic [31:0] rpc;
    logic [31:0] st0, st1, en0, en1;
    logic [15:0] c0, c1;
  } item_t;

  item_t       sbq[$];
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;
  logic [31:0] m_st[2], m_en[2];
  logic [15:0] m_c[2];

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step(string req, bit cv, logic [2:0] op, int set, logic [31:0] pc,
                      logic [31:0] addr, logic [31:0] off, logic [15:0] cnt,
                      bit fv, logic [31:0] fpc);
    item_t it;
    int win;
    @(negedge clk);
    cmd_valid = cv; cmd_op = op; cmd_set = set[0]; cmd_pc = pc; cmd_addr = addr;
    cmd_off = off; cmd_cnt = cnt; fetch_valid = fv; fetch_pc = fpc;
    win = -1;
    for (int i = 0; i < 2; i++)
      if (win < 0 && fv && fpc == m_en[i] && m_c[i] != 0) win = i;
    it.req = req;
    it.rv  = (win >= 0) && (m_c[win] > 1);
    it.rpc = (win >= 0) ? m_st[win] : 32'h0;
    if (win >= 0) m_c[win] = m_c[win] - 1;
    if (cv) begin
      if (op == 3'd1) m_st[set] = addr;
      if (op == 3'd2) m_en[set] = addr;
      if (op == 3'd3) m_c[set] = cnt;
      if (op == 3'd4) begin
        m_st[set] = pc + 4; m_en[set] = pc + 4 + off; m_c[set] = cnt;
      end
    end
    it.st0 = m_st[0]; it.st1 = m_st[1]; it.en0 = m_en[0]; it.en1 = m_en[1];
    it.c0 = m_c[0]; it.c1 = m_c[1];
    sbq.push_back(it);
  endtask

  // monitor: redirect checked before the rising edge, contexts after it
  initial begin
    forever begin
      item_t it;
      @(negedge clk); #1;
      if (sbq.size() != 0) begin
        it = sbq.pop_front();
        chk(it.req, "redirect_valid", {31'b0, redirect_valid}, {31'b0, it.rv});
        if (it.rv) chk(it.req, "redirect_pc", redirect_pc, it.rpc);
        @(posedge clk); #1;
        chk(it.req, "first0", loop_start_o[31:0], it.st0);
        chk(it.req, "first1", loop_start_o[63:32], it.st1);
        chk(it.req, "last0", loop_end_o[31:0], it.en0);
        chk(it.req, "last1", loop_end_o[63:32], it.en1);
        chk(it.req, "cnt0", {16'b0, loop_cnt_o[15:0]}, {16'b0, it.c0});
        chk(it.req, "cnt1", {16'b0, loop_cnt_o[31:16]}, {16'b0, it.c1});
      end
    end
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 2; i++) begin m_st[i] = 0; m_en[i] = 0; m_c[i] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state
    step("R1", 0, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    // R2 R3 R4 per-field setup of context 0
    step("R2", 1, 3'd1, 0, 0, 32'h100, 0, 0, 0, 0);
    step("R3", 1, 3'd2, 0, 0, 32'h10c, 0, 0, 0, 0);
    step("R4", 1, 3'd3, 0, 0, 0, 0, 16'd3, 0, 0);
    // R6 non-matching PC, then two jumps
    step("R6", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h108);
    step("R6", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h10c);
    step("R6", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h10c);
    // R7 last pass falls through
    step("R7", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h10c);
    // R8 inactive context ignores fetch
    step("R8", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h10c);
    // R11 fetch_valid low
    step("R11", 1, 3'd3, 0, 0, 0, 0, 16'd5, 0, 0);
    step("R11", 0, 3'd0, 0, 0, 0, 0, 0, 0, 32'h10c);
    // R5 combined setup for both contexts, same last address
    step("R5", 1, 3'd4, 1, 32'h200, 0, 32'h20, 16'd2, 0, 0);
    step("R5", 1, 3'd4, 0, 32'h210, 0, 32'h10, 16'd4, 0, 0);
    step("R5", 1, 3'd0, 0, 32'h300, 32'h44, 32'h8, 16'd9, 0, 0);
    // R9 context 0 wins
    step("R9", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h224);
    // R10 count write beats decrement
    step("R10", 1, 3'd3, 0, 0, 0, 0, 16'd7, 1, 32'h224);
    // R8 R9 inner idle: outer takes the match
    step("R8", 1, 3'd3, 0, 0, 0, 0, 16'd0, 0, 0);
    step("R9", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h224);
    step("R7", 0, 3'd0, 0, 0, 0, 0, 0, 1, 32'h224);
    step("R1", 0, 3'd0, 0, 0, 0, 0, 0, 0, 0);
    while (sbq.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule